// File: doc/BRIEF.md
# Completion-Detecting Carry-Select Adder

This block is a clocked model of a self-timed carry-select adder, in which each clock tick stands for one unit gate delay. The N-bit operands are split into blocks of M bits. Each block runs two ripple chains side by side, one with an assumed block carry-in of 0 and one with 1. Each chain advances one bit per tick. A selection chain then passes the real block carries upward at one block per tick.

Completion is detected from the pair of potential carries at the top of each block. The two values act as a natural dual-rail code. A block whose pair becomes equal already knows its carry-out and releases its carry flag without waiting for its neighbour. Any other block waits for the block below it. The done output rises once every block carry flag has cleared, so the time to done depends on the operands. The longest run of all-propagate blocks sets that time.

For block sizes above two, each block also keeps a sum-ready flag. That flag clears one tick after the block's internal ripple has settled, and done waits for it as well. At the default block size of two the potential sums always settle before the earliest carry flag can clear, so these flags are left out.

Top module: `scs_adder`

## Requirements
- R1: When done is high, {cout, sum} equals a + b + cin as an N+1 bit value, using the operands sampled at the accepting edge.
- R2: Per bit, propagate is a XOR b and generate is a AND b. A block's potential-carry pair (lo, hi) reads (0,1) while the block is unresolved, and equal values give the block carry directly. The pair (1,0) never occurs. If every propagate bit is 0, done is high after the 4th rising edge, counting the accepting edge as the 1st.
- R3: a, b and cin are sampled only at the accepting edge. Changing them later has no effect on the result or on the latency.
- R4: A block carry flag clears one tick after its pair becomes equal, or one tick after both of these hold: the block below has cleared its flag, and the block's own top chain bit has settled. With the defaults, a = 2^32-1, b = 1, cin = 0 gives done after edge 20.
- R5: Done is never later than edge 2 + M + N/M (36 with the defaults). It is exactly at that edge when every propagate bit is 1.
- R6: Done is high only while every block carry flag, and every sum-ready flag if present, is clear. While done stays high, sum and cout do not change.
- R7: A start is accepted on an edge where start is 1, start was 0 at the previous edge, and no addition is running. A rising start during a run is ignored. A start held high after done does not begin a new addition.
- R8: After reset, done, sum and cout are 0, and they stay 0 while idle.
- R9: Done falls on the accepting edge. Until a block's incoming carry has resolved, that block drives 0 on its sum bits. Cout stays 0 until the top block's carry has resolved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick per unit gate delay |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Rising edge begins an addition when idle or done |
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into the lowest bit |
| sum | output | N | Sum bits, gated per block until that block's carry-in resolves |
| cout | output | 1 | Carry out of the top block |
| done | output | 1 | Registered completion flag |

## Verification
Latency is counted in rising edges, with the accepting edge as the 1st. Done is due after edge 4 when no bit propagates and after edge 36 when every bit propagates, with the defaults. A single propagate run across blocks 1 to 15 places done after edge 20. The bench drives inputs and samples outputs at falling edges, so each count is exact and does not depend on process order.

The negedge right after the accepting edge is used to check that done has already fallen and that the upper sum bits and cout are gated to 0. Every later negedge is used to step the edge counter until done appears. The sum is compared at that same sample. It is then re-checked on three more edges while start stays high and the operands are disturbed.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } add_state_e;

    // potential carries of one block for assumed carry-in 0 (lo) and 1 (hi)
    typedef struct packed {
        logic lo;
        logic hi;
    } cpair_t;

    // edges from acceptance to done in the slowest case
    function automatic int worst_ticks(input int width, input int blk);
        return 2 + blk + width / blk;
    endfunction

endpackage

// File: rtl/scs_blk_chain.sv
module scs_blk_chain
    import scs_pkg::*;
#(
    parameter int BW       = 2,
    parameter bit SUM_FLAG = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          step,
    input  logic [BW-1:0] prop,
    input  logic [BW-1:0] gen,
    output logic [BW-1:0] c_lo,
    output logic [BW-1:0] c_hi,
    output logic [BW-1:0] pend,
    output logic [BW-1:0] s_lo,
    output logic [BW-1:0] s_hi,
    output logic          sum_busy
);

    logic [BW-1:0] below_lo, below_hi, below_pd;
    logic [BW-1:0] lo_nx, hi_nx, pend_nx;

    // carry entering each bit: block base constant, or the registered bit below
    assign below_lo = {c_lo[BW-2:0], 1'b0};
    assign below_hi = {c_hi[BW-2:0], 1'b1};
    assign below_pd = {pend[BW-2:0], 1'b0};

    assign lo_nx   = (prop & below_lo) | (~prop & gen);
    assign hi_nx   = (prop & below_hi) | (~prop & gen);
    assign pend_nx = pend & prop & below_pd;

    assign s_lo = prop ^ below_lo;
    assign s_hi = prop ^ below_hi;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            c_lo <= '0;
            c_hi <= '1;
            pend <= '1;
        end else if (step) begin
            c_lo <= lo_nx;
            c_hi <= hi_nx;
            pend <= pend_nx;
        end
    end

    generate
        if (SUM_FLAG) begin : g_sum_flag
            always_ff @(posedge clk) begin
                if (rst || init) sum_busy <= 1'b1;
                else if (step)   sum_busy <= |pend;
            end

            // R6: the sum flag is clear only once the internal chain has settled
            p_sumflag_settled_r6: assert property (@(posedge clk) disable iff (rst)
                !sum_busy |-> (pend == '0));
        end else begin : g_no_sum_flag
            assign sum_busy = 1'b0;
        end
    endgenerate

    // R2: the lo chain never carries where the hi chain does not
    p_pair_order_r2: assert property (@(posedge clk) disable iff (rst)
        (c_lo & ~c_hi) == '0);

    // R2: resolution markers only return to pending through initialisation
    p_marker_monotone_r2: assert property (@(posedge clk) disable iff (rst)
        ($countones(pend) > $countones($past(pend))) |-> $past(init));

endmodule

// File: rtl/scs_sel_link.sv
module scs_sel_link
    import scs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   init,
    input  logic   step,
    input  logic   prev_ready,
    input  logic   prev_carry,
    input  cpair_t pair,
    input  logic   top_settled,
    output logic   busy,
    output logic   carry
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            busy  <= 1'b1;
            carry <= 1'b0;
        end else if (step && busy) begin
            if (pair.lo == pair.hi) begin
                carry <= pair.lo;
                busy  <= 1'b0;
            end else if (top_settled && prev_ready) begin
                carry <= prev_carry;
                busy  <= 1'b0;
            end
        end
    end

    // R4: a flag clears only on an anticipated pair or a resolved predecessor
    p_clear_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(pair.lo == pair.hi) || $past(prev_ready && top_settled)));

    // R4: once cleared, the selected carry does not move until reinitialised
    p_carry_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !init) |=> $stable(carry));

endmodule

// File: rtl/scs_adder.sv
module scs_adder
    import scs_pkg::*;
#(
    parameter int N = 64,
    parameter int M = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout,
    output logic         done
);

    localparam int H        = N / M;
    localparam bit SUM_FLAG = (M > 2);
    localparam int WORST    = worst_ticks(N, M);
    localparam int CW       = $clog2(WORST) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(WORST - 2);

    add_state_e   st;
    logic         start_q, cin_q;
    logic [N-1:0] a_q, b_q;
    logic         accept, init, step, all_clear;
    logic [N-1:0] prop, gen;
    logic [N-1:0] clo, chi, pend_all, sl, sh;
    logic [H-1:0] busy, bcarry, sbusy, in_ok, in_c;

    assign accept = start && !start_q && (st != ST_RUN);
    assign init   = accept || (st == ST_IDLE && !start);
    assign step   = (st == ST_RUN);
    assign prop   = a_q ^ b_q;
    assign gen    = a_q & b_q;

    generate
        for (genvar c = 0; c < H; c++) begin : g_blk
            cpair_t top_pair;

            scs_blk_chain #(.BW(M), .SUM_FLAG(SUM_FLAG)) u_chain (
                .clk      (clk),
                .rst      (rst),
                .init     (init),
                .step     (step),
                .prop     (prop[c*M +: M]),
                .gen      (gen[c*M +: M]),
                .c_lo     (clo[c*M +: M]),
                .c_hi     (chi[c*M +: M]),
                .pend     (pend_all[c*M +: M]),
                .s_lo     (sl[c*M +: M]),
                .s_hi     (sh[c*M +: M]),
                .sum_busy (sbusy[c])
            );

            assign top_pair = '{lo: clo[c*M+M-1], hi: chi[c*M+M-1]};

            if (c == 0) begin : g_base
                assign in_ok[c] = (st != ST_IDLE);
                assign in_c[c]  = cin_q;
            end else begin : g_upper
                assign in_ok[c] = ~busy[c-1];
                assign in_c[c]  = bcarry[c-1];
            end

            scs_sel_link u_link (
                .clk         (clk),
                .rst         (rst),
                .init        (init),
                .step        (step),
                .prev_ready  (in_ok[c]),
                .prev_carry  (in_c[c]),
                .pair        (top_pair),
                .top_settled (~pend_all[c*M+M-1]),
                .busy        (busy[c]),
                .carry       (bcarry[c])
            );

            assign sum[c*M +: M] = in_ok[c] ? (in_c[c] ? sh[c*M +: M] : sl[c*M +: M]) : '0;
        end
    endgenerate

    assign cout      = ~busy[H-1] & bcarry[H-1];
    assign all_clear = ~|busy && ~|sbusy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            start_q <= 1'b0;
            a_q     <= '0;
            b_q     <= '0;
            cin_q   <= 1'b0;
            done    <= 1'b0;
        end else begin
            start_q <= start;
            if (accept) begin
                a_q   <= a;
                b_q   <= b;
                cin_q <= cin;
                st    <= ST_RUN;
                done  <= 1'b0;
            end else if (st == ST_RUN && all_clear) begin
                st   <= ST_DONE;
                done <= 1'b1;
            end
        end
    end

    // ticks spent running, kept for the latency bound check below
    logic [CW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst || accept)                     run_cnt <= '0;
        else if (st == ST_RUN && run_cnt != '1) run_cnt <= run_cnt + 1'b1;
    end

    p_result_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ({cout, sum} == ({1'b0, a_q} + {1'b0, b_q} + {{N{1'b0}}, cin_q})));

    p_operands_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(st == ST_RUN) && st == ST_RUN) |-> ($stable(a_q) && $stable(b_q) && $stable(cin_q)));

    p_worst_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (run_cnt <= LIMIT));

    p_done_flags_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> all_clear);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> ($stable(sum) && $stable(cout)));

endmodule

// File: tb/test_scs_adder.sv
module test_scs_adder;

    localparam int N     = 64;
    localparam int M     = 2;
    localparam int WORST = 2 + M + N / M;
    localparam int NV    = 9;

    // operand table: a, b, cin, expected edge count to done (0 = bound only)
    localparam logic [63:0] VA [NV] = '{
        64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h5555_5555_5555_5555, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_FFFF_FFFF};
    localparam logic [63:0] VB [NV] = '{
        64'h0, 64'h0, 64'h1,
        64'hAAAA_AAAA_AAAA_AAAA, 64'h0FED_CBA9_8765_4321, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0001};
    localparam bit VC [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam int VL [NV] = '{4, WORST, WORST, WORST, 0, 4, 4, 0, 20};

    logic         clk = 1'b0;
    logic         rst, start, cin, cout, done;
    logic [N-1:0] a, b, sum;
    int           checks = 0;
    int           errors = 0;

    always #2 clk = ~clk;

    scs_adder #(.N(N), .M(M)) i_scs_adder (
        .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_add(input logic [63:0] xa, input logic [63:0] xb, input logic xc,
                          input int exp_lat, input bit scramble, input bit glitch);
        logic [64:0] expv;
        logic [64:0] held;
        int n;
        expv = {1'b0, xa} + {1'b0, xb} + {64'h0, xc};
        a = xa; b = xb; cin = xc; start = 1'b1;
        @(posedge clk); n = 1; @(negedge clk);
        chk(done == 1'b0, "R9 done falls on accept edge", {64'h0, done}, 65'h0);
        chk(sum[N-1:M] == '0 && cout == 1'b0, "R9 upper sum and cout gated",
            {cout, sum}, {1'b0, 62'h0, sum[M-1:0]});
        if (scramble) begin a = ~xa; b = xa; cin = ~xc; end
        if (glitch) begin
            start = 1'b0; @(posedge clk); n++; @(negedge clk);
            start = 1'b1;
        end
        while (!done && n < 200) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk({cout, sum} == expv, "R1 sum result", {cout, sum}, expv);
        if (exp_lat != 0)
            chk(n == exp_lat, "R5/R2/R4 exact latency", 65'(n), 65'(exp_lat));
        else
            chk(n >= 4 && n <= WORST, "R5 latency bound", 65'(n), 65'(WORST));
        held = {cout, sum};
        for (int k = 0; k < 3; k++) begin
            a = ~a; b = b + 64'd3; cin = ~cin;
            @(posedge clk); @(negedge clk);
            chk(done && {cout, sum} == held, "R7/R6/R3 held start keeps result",
                {cout, sum}, held);
        end
        start = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] s;
        rst = 1'b1; start = 1'b0; a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R8 reset done", {64'h0, done}, 65'h0);
        chk({cout, sum} == 65'h0, "R8 reset sum", {cout, sum}, 65'h0);
        rst = 1'b0;
        a = '1; b = '1; cin = 1'b1;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk({done, cout, sum} == 66'h0, "R8 idle outputs zero", {cout, sum}, 65'h0);

        for (int i = 0; i < NV; i++) do_add(VA[i], VB[i], VC[i], VL[i], 1'b0, 1'b0);

        // R3: operands disturbed right after acceptance, all-propagate case
        do_add(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, WORST, 1'b1, 1'b0);
        // R7: start rising again mid-run is ignored
        do_add(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, WORST, 1'b0, 1'b1);
        // R2: no propagate bits anywhere
        do_add(64'h0F0F_0F0F_F0F0_F0F0, 64'h0F0F_0F0F_F0F0_F0F0, 1'b1, 4, 1'b0, 1'b0);

        s = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 20; i++) begin
            logic [63:0] ra;
            s ^= s << 13; s ^= s >> 7; s ^= s << 17;
            ra = s;
            s ^= s << 13; s ^= s >> 7; s ^= s << 17;
            do_add(ra, s, s[5], 0, i[0], i[1]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule